// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host write port and a bank of 128-bit control registers. A 128-bit register cannot be written in one host access, so the block gathers the four dword writes that make it up. It then issues them to the register file as a single atomic 128-bit commit. Registers narrower than 128 bits pass straight through as 32-bit commits.

The address space is split into pages of 0x2000 bytes, one per virtual interface. The register address is page × 0x2000 plus an offset inside the page. Two offsets in every page hold descriptor-pointer registers, which get special handling. A write to the top dword of one of these always commits at once. Any low bits that have not been gathered are sent as zero. A write to the timer-command register in page 0 empties the collector.

The collector tracks one register at a time, using one valid bit per dword lane and a tag holding the 16-byte-aligned address. A write that would mix two registers is dropped, and the collector keeps its state.

Top module: `wrc_top`

## Requirements
- R1: After a synchronous active-high reset, no commit is issued and the collector is empty.
- R2: For an ordinary wide register (page offset below 0x400), the dword at byte address bits [3:2] = i is stored in bits [32i+31:32i]. Writes may arrive in any order. The cycle after the write that completes all four lanes, one single-cycle commit is issued with commit_wide = 1, the 16-byte-aligned address and the full 128-bit data. The collector then empties.
- R3: While fewer than four lanes of an ordinary wide register are held, no commit is issued.
- R4: A second write to a lane that is already held replaces the stored dword, so the later value is the one committed.
- R5: If the collector is not empty and an ordinary wide write has a different 16-byte-aligned address, that write is dropped. The lanes and data already held are kept.
- R6: A write to the top dword (offset 0x83c or 0xa1c) of a descriptor-pointer register (offset 0x830 or 0xa10) always commits the next cycle. If lanes 0 to 2 of the same register are held, the commit carries them in bits [95:0] and the new dword in bits [127:96].
- R7: If the lower three lanes of that register are not all held, a descriptor-pointer top write commits bits [95:0] as zero. If the collector held that register, it empties.
- R8: If the collector is not empty and holds a different register, a write to a lower dword of a descriptor-pointer register is dropped.
- R9: If the collector holds another register, a descriptor-pointer top write still commits with zero low bits, and the other register's collection is kept.
- R10: A write to any other offset of 0x400 or above bypasses the collector. The cycle after, it commits with commit_wide = 0, the dword-aligned address, and the data in bits [31:0] with the upper bits zero.
- R11: A write to the timer-command offset 0x420 in page 0 commits as in R10 and empties the collector. The same offset in any other page leaves the collector unchanged.
- R12: Descriptor-pointer handling applies in every page. The address is the page number in bits [15:13] and the offset in bits [12:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | 16 | Byte address of the dword; bits [1:0] are ignored |
| wr_data | input | 32 | Write data |
| commit_valid | output | 1 | Single-cycle commit strobe toward the register file |
| commit_wide | output | 1 | 1 for a 128-bit commit, 0 for a 32-bit commit |
| commit_addr | output | 16 | Commit address, aligned to 16 or 4 bytes |
| commit_data | output | 128 | Commit data |

## Verification
Every result is registered once, so a commit appears in the cycle after the edge that captures the write that caused it. A write that is dropped or only collected shows commit_valid low in that same cycle. The bench drives each write at a falling edge and compares all outputs at the next falling edge against its own model. This means each write is judged in exactly the cycle its result is due. The collector's internal state is never read directly: it is inferred from later commits, for example by finishing a held register after a dropped write or after a timer write.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {
    K_NARROW  = 2'd0,
    K_WIDE    = 2'd1,
    K_SPECIAL = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 13,
  parameter int LANE_W     = 2,
  parameter int WIDE_LIMIT = 'h400,
  parameter int SPEC_OFF_A = 'h830,
  parameter int SPEC_OFF_B = 'ha10,
  parameter int TIMER_OFF  = 'h420
) (
  input  logic [ADDR_W-1:0]        addr,
  output wr_kind_e                 kind,
  output logic [LANE_W-1:0]        lane,
  output logic [ADDR_W-LANE_W-3:0] tag,
  output logic                     is_top,
  output logic                     timer_clr
);
  localparam int ALIGN = LANE_W + 2;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] SA = OFF_W'(SPEC_OFF_A);
  localparam logic [OFF_W-1:0] SB = OFF_W'(SPEC_OFF_B);
  localparam logic [OFF_W-1:0] TM = OFF_W'(TIMER_OFF);
  localparam logic [OFF_W-1:0] WL = OFF_W'(WIDE_LIMIT);

  logic [OFF_W-1:0]  off;
  logic [PAGE_W-1:0] page;
  logic              spec;

  assign off  = addr[OFF_W-1:0];
  assign page = addr[ADDR_W-1:OFF_W];
  assign lane = addr[ALIGN-1:2];
  assign tag  = addr[ADDR_W-1:ALIGN];
  assign is_top = &lane;
  assign spec = (off[OFF_W-1:ALIGN] == SA[OFF_W-1:ALIGN]) ||
                (off[OFF_W-1:ALIGN] == SB[OFF_W-1:ALIGN]);
  assign timer_clr = (off[OFF_W-1:2] == TM[OFF_W-1:2]) && (page == '0);

  always_comb begin
    if (spec)            kind = K_SPECIAL;
    else if (off < WL)   kind = K_WIDE;
    else                 kind = K_NARROW;
  end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
  import wrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int TAG_W  = 12,
  localparam int LANE_W = $clog2(LANES),
  localparam int WIDE_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  wr_kind_e          kind,
  input  logic [LANE_W-1:0] lane,
  input  logic [TAG_W-1:0]  tag,
  input  logic              is_top,
  input  logic              timer_clr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fire,
  output logic [WIDE_W-1:0] fire_data
);
  logic [LANES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q [LANES];

  logic match, empty, accept, full_norm, spec_top, spec_full, clear;
  logic [LANES-1:0] lane_hot, valid_after;

  assign match    = (tag_q == tag);
  assign empty    = (valid_q == '0);
  assign lane_hot = LANES'(1) << lane;
  assign accept   = wr_en && (kind == K_WIDE || (kind == K_SPECIAL && !is_top)) &&
                    (empty || match);
  assign valid_after = valid_q | (accept ? lane_hot : '0);
  assign full_norm = accept && (kind == K_WIDE) && (&valid_after);
  assign spec_top  = wr_en && (kind == K_SPECIAL) && is_top;
  assign spec_full = spec_top && match && (&valid_q[LANES-2:0]);
  assign fire      = full_norm || spec_top;
  assign clear     = (wr_en && timer_clr) || full_norm || (spec_top && match);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (clear) begin
      valid_q <= '0;
    end else if (accept) begin
      valid_q <= valid_after;
      tag_q   <= tag;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] merged;
    assign merged = (accept && lane_hot[i]) ? wr_data : data_q[i];

    always_ff @(posedge clk) begin
      if (accept && lane_hot[i]) data_q[i] <= wr_data;
    end

    if (i == LANES - 1) begin : g_top
      assign fire_data[i*DATA_W +: DATA_W] = spec_top ? wr_data : merged;
    end else begin : g_low
      assign fire_data[i*DATA_W +: DATA_W] =
        spec_top ? (spec_full ? data_q[i] : '0) : merged;
    end
  end

  // R5: a mismatching ordinary write leaves the collector untouched
  a_r5_drop_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_WIDE && !empty && !match) |=> ($stable(valid_q) && $stable(tag_q)));

  // R11: page-0 timer write empties the collector
  a_r11_timer_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && timer_clr) |=> (valid_q == '0));

  // R7: top write of the held descriptor register empties the collector
  a_r7_top_clears: assert property (@(posedge clk) disable iff (rst)
    (spec_top && match) |=> (valid_q == '0));

  // R8: a conflicting low descriptor write is not collected
  a_r8_spec_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_SPECIAL && !is_top && !empty && !match) |=> $stable(valid_q));
endmodule

// File: rtl/wrc_commit_reg.sv
module wrc_commit_reg #(
  parameter int ADDR_W = 16,
  parameter int WIDE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_wide,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WIDE_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wide  <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_wide <= in_wide;
        out_addr <= in_addr;
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/wrc_top.sv
module wrc_top
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LANES      = 4,
  parameter int OFF_W      = 13,
  parameter int WIDE_LIMIT = 'h400,
  parameter int SPEC_OFF_A = 'h830,
  parameter int SPEC_OFF_B = 'ha10,
  parameter int TIMER_OFF  = 'h420,
  localparam int LANE_W = $clog2(LANES),
  localparam int ALIGN  = LANE_W + 2,
  localparam int TAG_W  = ADDR_W - ALIGN,
  localparam int WIDE_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_valid,
  output logic              commit_wide,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WIDE_W-1:0] commit_data
);
  wr_kind_e          kind;
  logic [LANE_W-1:0] lane;
  logic [TAG_W-1:0]  tag;
  logic              is_top, timer_clr, fire;
  logic [WIDE_W-1:0] fire_data;
  logic              nx_valid, narrow;
  logic [ADDR_W-1:0] nx_addr;
  logic [WIDE_W-1:0] nx_data;

  wrc_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W), .WIDE_LIMIT(WIDE_LIMIT),
    .SPEC_OFF_A(SPEC_OFF_A), .SPEC_OFF_B(SPEC_OFF_B), .TIMER_OFF(TIMER_OFF)
  ) u_dec (
    .addr(wr_addr), .kind(kind), .lane(lane), .tag(tag),
    .is_top(is_top), .timer_clr(timer_clr)
  );

  wrc_collector #(.DATA_W(DATA_W), .LANES(LANES), .TAG_W(TAG_W)) u_col (
    .clk(clk), .rst(rst), .wr_en(wr_en), .kind(kind), .lane(lane), .tag(tag),
    .is_top(is_top), .timer_clr(timer_clr), .wr_data(wr_data),
    .fire(fire), .fire_data(fire_data)
  );

  assign narrow   = wr_en && (kind == K_NARROW);
  assign nx_valid = narrow || fire;
  assign nx_addr  = narrow ? {wr_addr[ADDR_W-1:2], 2'b00} : {tag, {ALIGN{1'b0}}};
  assign nx_data  = narrow ? {{(WIDE_W-DATA_W){1'b0}}, wr_data} : fire_data;

  wrc_commit_reg #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(nx_valid), .in_wide(!narrow),
    .in_addr(nx_addr), .in_data(nx_data),
    .out_valid(commit_valid), .out_wide(commit_wide),
    .out_addr(commit_addr), .out_data(commit_data)
  );

  // R6: a descriptor top write always commits wide next cycle
  a_r6_top_commits: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_SPECIAL && is_top) |=> (commit_valid && commit_wide));

  // R10: bypass writes commit narrow next cycle
  a_r10_narrow_next: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_NARROW) |=> (commit_valid && !commit_wide));

  // R3: no commit appears without a write in the cycle before
  a_r3_commit_needs_write: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> $past(wr_en));

  // R10: a narrow commit carries zero above its dword
  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && !commit_wide) |-> (commit_data[WIDE_W-1:DATA_W] == '0));
endmodule

// File: tb/wrc_top_tb.sv
module wrc_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [15:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         commit_valid, commit_wide;
  logic [15:0]  commit_addr;
  logic [127:0] commit_data;

  int checks = 0;
  int errors = 0;

  logic [3:0]   m_valid;
  logic [11:0]  m_tag;
  logic [127:0] m_data;

  always #2.5 clk = ~clk;

  wrc_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_valid(commit_valid), .commit_wide(commit_wide),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  function automatic logic [15:0] mk(input int page, input int off);
    return 16'((page << 13) | off);
  endfunction

  task automatic step(input bit en, input logic [15:0] a, input logic [31:0] d);
    bit exp_v = 0, exp_w = 0;
    logic [15:0] exp_a = '0;
    logic [127:0] exp_d = '0;
    string req = "R3";
    logic [12:0] off = a[12:0];
    logic [2:0] pg = a[15:13];
    int ln = int'(a[3:2]);
    logic [11:0] tg = a[15:4];
    bit spec = (off[12:4] == 9'h083) || (off[12:4] == 9'h0a1);
    bit wide = spec || (off < 13'h400);
    if (en) begin
      if (!wide) begin
        exp_v = 1; exp_a = {a[15:2], 2'b00}; exp_d = {96'b0, d}; req = "R10";
        if (off[12:2] == 11'h108 && pg == 3'd0) begin m_valid = '0; req = "R11"; end
      end else if (spec && ln == 3) begin
        exp_v = 1; exp_w = 1; exp_a = {tg, 4'b0};
        if (m_tag == tg && m_valid[2:0] == 3'b111) begin
          exp_d = {d, m_data[95:0]}; req = "R6";
        end else begin
          exp_d = {d, 96'b0}; req = (m_valid != 0 && m_tag != tg) ? "R9" : "R7";
        end
        if (m_tag == tg) m_valid = '0;
      end else if (m_valid == 0 || m_tag == tg) begin
        m_valid[ln] = 1'b1; m_data[ln*32 +: 32] = d; m_tag = tg;
        if (!spec && m_valid == 4'hf) begin
          exp_v = 1; exp_w = 1; exp_a = {tg, 4'b0}; exp_d = m_data; req = "R2";
          m_valid = '0;
        end
      end else begin
        req = spec ? "R8" : "R5";
      end
    end
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    checks++;
    if (commit_valid !== exp_v ||
        (exp_v && (commit_wide !== exp_w || commit_addr !== exp_a || commit_data !== exp_d))) begin
      errors++;
      $display("FAIL %s: got v=%0b w=%0b a=%h d=%h exp v=%0b w=%0b a=%h d=%h",
               req, commit_valid, commit_wide, commit_addr, commit_data,
               exp_v, exp_w, exp_a, exp_d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_valid = '0; m_tag = '0; m_data = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: no commit right after reset
    step(0, '0, '0);
    // R2: four lanes out of order; R3 partials silent
    step(1, mk(0, 'h018), 32'h2222_2222);
    step(1, mk(0, 'h010), 32'h0000_0000);
    step(1, mk(0, 'h01c), 32'h3333_3333);
    // R4: rewrite of lane 0
    step(1, mk(0, 'h010), 32'h0a0a_0a0a);
    // R5: mismatching write dropped
    step(1, mk(1, 'h020), 32'hdead_beef);
    step(1, mk(0, 'h014), 32'h1111_1111);
    // R6: full descriptor register in page 0
    step(1, mk(0, 'h830), 32'h0c0c_0000);
    step(1, mk(0, 'h834), 32'h0c0c_0001);
    step(1, mk(0, 'h838), 32'h0c0c_0002);
    step(1, mk(0, 'h83c), 32'h0c0c_0003);
    // R7: partial descriptor, zero filled
    step(1, mk(0, 'ha14), 32'h7777_7777);
    step(1, mk(0, 'ha1c), 32'h7777_0003);
    // R8 and R9: collector holds normal reg
    step(1, mk(0, 'h030), 32'h9999_0000);
    step(1, mk(2, 'h830), 32'h8888_8888);
    step(1, mk(2, 'h83c), 32'h9999_1111);
    step(1, mk(0, 'h034), 32'h9999_0001);
    step(1, mk(0, 'h038), 32'h9999_0002);
    step(1, mk(0, 'h03c), 32'h9999_0003);
    // R11: timer in page 3 keeps, page 0 clears
    step(1, mk(0, 'h040), 32'h4444_0000);
    step(1, mk(3, 'h420), 32'h0000_00aa);
    step(1, mk(0, 'h420), 32'h0000_00bb);
    step(1, mk(1, 'h040), 32'h5555_0000);
    // R10: plain narrow register
    step(1, mk(4, 'h500), 32'hcafe_f00d);
    // R12: descriptor in page 5 at second offset
    step(1, mk(5, 'ha10), 32'h5a5a_0000);
    step(1, mk(5, 'ha14), 32'h5a5a_0001);
    step(1, mk(5, 'ha18), 32'h5a5a_0002);
    step(1, mk(5, 'ha1c), 32'h5a5a_0003);
    // R1: reset mid-collection empties the collector
    rst = 1'b1; @(negedge clk); rst = 1'b0; m_valid = '0;
    step(1, mk(5, 'ha1c), 32'h1234_5678);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom % 9);
      int ln = int'($urandom % 4);
      logic [31:0] d = $urandom;
      logic [15:0] a;
      case (sel)
        0: a = mk(0, 'h010 + 4*ln);
        1: a = mk(0, 'h020 + 4*ln);
        2: a = mk(1, 'h010 + 4*ln);
        3: a = mk(0, 'h830 + 4*ln);
        4: a = mk(3, 'ha10 + 4*ln);
        5: a = mk(0, 'h500);
        6: a = mk(0, 'h420);
        7: a = mk(2, 'h420);
        default: a = mk(6, 'h830 + 4*ln);
      endcase
      step(($urandom % 8) != 0, a, d);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule